// File: doc/BRIEF.md
# Square-Channel Frequency Sweep Unit

This block bends the pitch of a square-wave tone channel over time. It holds the channel's 11-bit timer period and, on a programmable fraction of the half-frame ticks, adds or subtracts a right-shifted copy of that period. A larger period gives a lower pitch and a smaller one a higher pitch. Each evaluation also forms a target period. When the target falls outside the range the timer can use, the block raises a mute flag, and the channel silences itself on that flag.

Software programs the unit with one byte-wide sweep write and loads the period directly. A build parameter chooses how a downward sweep negates the shifted value. Ones' complement subtracts one extra count, and two's complement gives an exact difference, so two channel instances can differ on purpose. All pins are plain control and status signals. No data stream crosses the edge of the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sq_sweep_unit`

## Requirements
- R1: A divider counts down by one on each `half_tick`. On a tick that finds it at 0, it reloads from the divider period and the sweep is evaluated, so an unbroken run of ticks evaluates once every (divider period + 1) ticks.
- R2: A `sweep_wr` decodes `sweep_data` as enable in bit 7, divider period in bits 6:4, negate in bit 3 and shift count in bits 2:0, and it sets a reload flag. The next tick reloads the divider and clears the flag. That tick evaluates only if the divider was already 0.
- R3: With negate clear, the target equals P + (P >> S), where P is the period and S is the shift count.
- R4: With negate set, the target is taken modulo 2^16. It equals P - (P >> S) - 1 when TWOS_COMP = 0, and P - (P >> S) when TWOS_COMP = 1.
- R5: At each enabled evaluation, `muted` takes the value (target < 8 or target >= 2048). At no other time does it change, and a period load does not change it either.
- R6: At an enabled evaluation the period takes the target only when the target is not muted and S is nonzero. Otherwise the period keeps its value.
- R7: A `period_wr` loads `period_data` into the period one clock later. It takes priority over a sweep update in the same cycle.
- R8: With enable clear, ticks change neither the period nor `muted`.
- R9: After reset, `period` is 0, `muted` is 0, the divider is 0 and the reload flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_tick | input | 1 | Half-frame clock enable, one cycle wide |
| sweep_wr | input | 1 | Strobe for a write to the sweep setup |
| sweep_data | input | 8 | Sweep setup byte: enable[7], divider period[6:4], negate[3], shift[2:0] |
| period_wr | input | 1 | Strobe for a direct load of the timer period |
| period_data | input | PERIOD_W | Timer period value to load |
| period | output | PERIOD_W | Current timer period |
| muted | output | 1 | Target period out of range; the channel should be silent |

## Verification
A wrong divider count moves an evaluation to the wrong tick. The period then changes one or more half-frame ticks early or late, which the per-clock comparison catches within the first sweep step. A reload flag that is set or cleared incorrectly shifts the next update by up to divider-period ticks. A negation or adder error shows at the first downward step as a period that is off by one or more, and the two complement variants are compared side by side. A mute decision that is wrong or stale shows on `muted` one clock after the evaluating tick. It can also show as a period that should have frozen but kept moving, or the reverse.

// File: rtl/sq_sweep_pkg.sv
package sq_sweep_pkg;
  localparam int DIV_W   = 3;
  localparam int SHIFT_W = 3;

  typedef struct packed {
    logic               enable;
    logic [DIV_W-1:0]   div_period;
    logic               negate;
    logic [SHIFT_W-1:0] shift;
  } sweep_cfg_t;

  function automatic sweep_cfg_t decode_cfg(input logic [7:0] raw);
    sweep_cfg_t c;
    c.enable     = raw[7];
    c.div_period = raw[6:4];
    c.negate     = raw[3];
    c.shift      = raw[2:0];
    return c;
  endfunction
endpackage

// File: rtl/sq_sweep_divider.sv
module sq_sweep_divider #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] div_period,
  output logic             fire
);
  logic [DIV_W-1:0] count;
  logic             reload;

  assign fire = tick && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= 1'b0;
    end else begin
      if (tick) begin
        if (count == '0 || reload) count <= div_period;
        else                       count <= count - 1'b1;
      end
      if (cfg_wr)    reload <= 1'b1;
      else if (tick) reload <= 1'b0;
    end
  end

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count)) else $error("divider moved without tick"); // R1
  AST_RELOAD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cfg_wr |=> !reload) else $error("reload flag survived tick"); // R2
  AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> reload) else $error("write did not arm reload"); // R2
endmodule

// File: rtl/sq_sweep_target.sv
module sq_sweep_target
  import sq_sweep_pkg::*;
#(
  parameter int PERIOD_W   = 11,
  parameter int MIN_PERIOD = 8,
  parameter bit TWOS_COMP  = 1'b0,
  localparam int ACC_W     = PERIOD_W + 5
) (
  input  logic [PERIOD_W-1:0] period,
  input  sweep_cfg_t          cfg,
  output logic [ACC_W-1:0]    target,
  output logic                out_of_range
);
  logic [ACC_W-1:0] p_ext;
  logic [ACC_W-1:0] delta;
  logic [ACC_W-1:0] addend;

  assign p_ext = ACC_W'(period);
  assign delta = p_ext >> cfg.shift;

  generate
    if (TWOS_COMP) begin : g_twos
      assign addend = cfg.negate ? (~delta + 1'b1) : delta;
    end else begin : g_ones
      assign addend = cfg.negate ? ~delta : delta;
    end
  endgenerate

  assign target       = p_ext + addend;
  assign out_of_range = (target < ACC_W'(MIN_PERIOD)) ||
                        (|target[ACC_W-1:PERIOD_W]);

  always_comb begin
    if (!cfg.negate) begin
      AST_UP_GROWS: assert (target >= p_ext) else $error("upward sweep shrank"); // R3
    end
    if (cfg.negate && !out_of_range) begin
      AST_DOWN_SHRINKS: assert (target <= p_ext) else $error("downward sweep grew"); // R4
    end
  end
endmodule

// File: rtl/sq_sweep_period.sv
module sq_sweep_period #(
  parameter int PERIOD_W   = 11,
  parameter int MIN_PERIOD = 8,
  localparam int ACC_W     = PERIOD_W + 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eval,
  input  logic                shift_nz,
  input  logic [ACC_W-1:0]    target,
  input  logic                target_bad,
  input  logic                load,
  input  logic [PERIOD_W-1:0] load_value,
  output logic [PERIOD_W-1:0] period,
  output logic                muted
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '0;
      muted  <= 1'b0;
    end else begin
      if (eval) begin
        muted <= target_bad;
        if (!target_bad && shift_nz) period <= target[PERIOD_W-1:0];
      end
      if (load) period <= load_value;
    end
  end

  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !eval |=> $stable(period)) else $error("period moved idle"); // R8
  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    eval && !shift_nz && !load |=> $stable(period)) else $error("shift 0 moved period"); // R6
  AST_UPDATE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    eval && !load |=> $stable(period) || period >= PERIOD_W'(MIN_PERIOD))
    else $error("period swept below minimum"); // R6
  AST_MUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable(muted)) else $error("mute changed off evaluation"); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> period == $past(load_value)) else $error("period load lost"); // R7
endmodule

// File: rtl/sq_sweep_unit.sv
module sq_sweep_unit
  import sq_sweep_pkg::*;
#(
  parameter int PERIOD_W   = 11,
  parameter int MIN_PERIOD = 8,
  parameter bit TWOS_COMP  = 1'b0,
  localparam int ACC_W     = PERIOD_W + 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                half_tick,
  input  logic                sweep_wr,
  input  logic [7:0]          sweep_data,
  input  logic                period_wr,
  input  logic [PERIOD_W-1:0] period_data,
  output logic [PERIOD_W-1:0] period,
  output logic                muted
);
  sweep_cfg_t       cfg;
  logic             fire;
  logic [ACC_W-1:0] target;
  logic             target_bad;
  logic             eval;

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg <= '0;
    else if (sweep_wr) cfg <= decode_cfg(sweep_data);
  end

  sq_sweep_divider #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (half_tick),
    .cfg_wr     (sweep_wr),
    .div_period (cfg.div_period),
    .fire       (fire)
  );

  sq_sweep_target #(
    .PERIOD_W   (PERIOD_W),
    .MIN_PERIOD (MIN_PERIOD),
    .TWOS_COMP  (TWOS_COMP)
  ) u_tgt (
    .period       (period),
    .cfg          (cfg),
    .target       (target),
    .out_of_range (target_bad)
  );

  assign eval = fire && cfg.enable;

  sq_sweep_period #(
    .PERIOD_W   (PERIOD_W),
    .MIN_PERIOD (MIN_PERIOD)
  ) u_per (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval       (eval),
    .shift_nz   (cfg.shift != '0),
    .target     (target),
    .target_bad (target_bad),
    .load       (period_wr),
    .load_value (period_data),
    .period     (period),
    .muted      (muted)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick && !cfg.enable && !period_wr |=> $stable(period) && $stable(muted))
    else $error("disabled sweep changed outputs"); // R8
endmodule

// File: tb/sq_sweep_unit_test.sv
module sq_sweep_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_tick = 1'b0;
  logic        sweep_wr = 1'b0;
  logic [7:0]  sweep_data = '0;
  logic        period_wr = 1'b0;
  logic [10:0] period_data = '0;
  logic [10:0] per_a, per_b;
  logic        mute_a, mute_b;

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R9";
  bit    running = 1'b0;

  always #10ns clk = ~clk;

  sq_sweep_unit #(.TWOS_COMP(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .sweep_wr(sweep_wr),
    .sweep_data(sweep_data), .period_wr(period_wr), .period_data(period_data),
    .period(per_a), .muted(mute_a));

  sq_sweep_unit #(.TWOS_COMP(1'b1)) uut2 (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .sweep_wr(sweep_wr),
    .sweep_data(sweep_data), .period_wr(period_wr), .period_data(period_data),
    .period(per_b), .muted(mute_b));

  // behavioural reference: index 0 ones' complement, 1 two's complement
  int m_div, m_rld, m_en, m_dp, m_neg, m_sh;
  int m_p[2];
  int m_m[2];

  always @(posedge clk) begin : model
    int fire, d, t;
    if (!rst_n) begin
      m_div = 0; m_rld = 0; m_en = 0; m_dp = 0; m_neg = 0; m_sh = 0;
      for (int v = 0; v < 2; v++) begin m_p[v] = 0; m_m[v] = 0; end
    end else begin
      fire = (half_tick && m_div == 0) ? 1 : 0;
      for (int v = 0; v < 2; v++) begin
        if (fire != 0 && m_en != 0) begin
          d = m_p[v] >> m_sh;
          if (m_neg != 0) t = m_p[v] - d - ((v == 1) ? 0 : 1);
          else            t = m_p[v] + d;
          t = (t + 65536) % 65536;
          m_m[v] = (t < 8 || t >= 2048) ? 1 : 0;
          if (m_m[v] == 0 && m_sh != 0) m_p[v] = t;
        end
        if (period_wr) m_p[v] = int'(period_data);
      end
      if (half_tick) m_div = (m_div == 0 || m_rld != 0) ? m_dp : m_div - 1;
      if (sweep_wr) begin
        m_rld = 1;
        m_en  = sweep_data[7];
        m_dp  = int'(sweep_data[6:4]);
        m_neg = sweep_data[3];
        m_sh  = int'(sweep_data[2:0]);
      end else if (half_tick) m_rld = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk({cur_tag, " period ones"}, int'(per_a), m_p[0]);
      chk({cur_tag, " period twos"}, int'(per_b), m_p[1]);
      chk({cur_tag, " muted ones"}, int'(mute_a), m_m[0]);
      chk({cur_tag, " muted twos"}, int'(mute_b), m_m[1]);
    end
  end

  task automatic do_tick();
    @(negedge clk) half_tick = 1'b1;
    @(negedge clk) half_tick = 1'b0;
  endtask

  task automatic load_period(input int p);
    @(negedge clk) begin period_wr = 1'b1; period_data = 11'(p); end
    @(negedge clk) period_wr = 1'b0;
  endtask

  task automatic set_sweep(input logic [7:0] b);
    @(negedge clk) begin sweep_wr = 1'b1; sweep_data = b; end
    @(negedge clk) sweep_wr = 1'b0;
  endtask

  task automatic both(input string tag, input int pa, input int pb, input int ma, input int mb);
    chk({tag, " period ones"}, int'(per_a), pa);
    chk({tag, " period twos"}, int'(per_b), pb);
    chk({tag, " muted ones"}, int'(mute_a), ma);
    chk({tag, " muted twos"}, int'(mute_b), mb);
  endtask

  initial begin
    #(20ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    running = 1'b1;
    both("R9 reset", 0, 0, 0, 0);
    @(negedge clk) rst_n = 1'b1;

    cur_tag = "R7";
    load_period(12'h100);
    both("R7 load", 12'h100, 12'h100, 0, 0);

    cur_tag = "R3";
    set_sweep(8'h91);                 // en, div 1, up, shift 1
    do_tick();
    both("R3 up step", 12'h180, 12'h180, 0, 0);
    cur_tag = "R1";
    do_tick();
    both("R1 divider wait", 12'h180, 12'h180, 0, 0);
    do_tick();
    both("R1 second step", 12'h240, 12'h240, 0, 0);

    cur_tag = "R2";
    set_sweep(8'hB1);                 // en, div 3, up, shift 1
    for (int i = 0; i < 4; i++) do_tick();
    both("R2 reload delays", 12'h240, 12'h240, 0, 0);
    do_tick();
    both("R1 div3 step", 12'h360, 12'h360, 0, 0);

    cur_tag = "R4";
    load_period(12'h200);
    set_sweep(8'h89);                 // en, div 0, negate, shift 1
    do_tick();
    both("R2 reload no eval", 12'h200, 12'h200, 0, 0);
    do_tick();
    both("R4 down step", 12'h0FF, 12'h100, 0, 0);
    do_tick();
    both("R4 down again", 12'h07F, 12'h080, 0, 0);

    cur_tag = "R5";
    load_period(10);
    do_tick();
    both("R5 mute low", 10, 10, 1, 1);
    load_period(12'h300);
    both("R5 load keeps mute", 12'h300, 12'h300, 1, 1);

    cur_tag = "R6";
    set_sweep(8'h80);                 // en, div 0, up, shift 0
    do_tick();
    both("R6 shift zero", 12'h300, 12'h300, 0, 0);

    cur_tag = "R5";
    load_period(12'h500);
    set_sweep(8'h81);
    do_tick();
    both("R3 up 500", 12'h780, 12'h780, 0, 0);
    do_tick();
    both("R5 mute high", 12'h780, 12'h780, 1, 1);

    cur_tag = "R8";
    set_sweep(8'h01);                 // disabled
    for (int i = 0; i < 3; i++) do_tick();
    both("R8 disabled", 12'h780, 12'h780, 1, 1);

    cur_tag = "R7";
    set_sweep(8'h81);
    load_period(12'h100);
    @(negedge clk) begin half_tick = 1'b1; period_wr = 1'b1; period_data = 11'h123; end
    @(negedge clk) begin half_tick = 1'b0; period_wr = 1'b0; end
    both("R7 load beats sweep", 12'h123, 12'h123, 0, 0);

    cur_tag = "R4";
    load_period(4);
    set_sweep(8'h8F);                 // negate, shift 7 -> delta 0
    do_tick();
    both("R4 zero delta", 4, 4, 1, 1);

    cur_tag = "R9";
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    both("R9 rerest", 0, 0, 0, 0);

    running = 1'b0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule